// File: doc/BRIEF.md
# GPIO Bank Interrupt Detector

This block watches every pin of a 95-pin general-purpose I/O bank and records interrupt events in sticky status bits. It receives each pin's already synchronized level, together with two configuration bits per pin (a trigger-type select and a polarity invert) and the pin's usage and input-sensing qualifiers from the pad configuration logic. Depending on the two trigger bits a pin records a rising edge, a falling edge, a low level or a high level.

Software reaches the block through a simple single-cycle register bus. The status bits are packed into 32-bit words and cleared by writing ones. The per-pin enable bits sit in a separate set of 32-bit words. A pin is pending only when its status and its enable are both set. A single registered interrupt line to the parent controller is the OR of all pending pins. Status is recorded even for pins that are not enabled, so software can poll them.

Top module: `gpio_irq_detect`

## Requirements
- R1: With trigger select 0 and invert 0, a pin sets its status bit on the clock edge where its level is 1 and was 0 on the previous edge; a falling level records nothing.
- R2: With trigger select 0 and invert 1, a pin sets its status bit on a 1-to-0 level change; a rising level records nothing.
- R3: With trigger select 1 and invert 0, a pin sets its status bit on every clock edge where its level is 0, so the bit is set again on the edge after a clear while the level stays low.
- R4: With trigger select 1 and invert 1, a pin sets its status bit on every clock edge where its level is 1; a low level records nothing.
- R5: Status word k is at byte address 0x80 + 4k and enable word k at 0x90 + 4k (k = 0..2). Pin p occupies bit p mod 32 of word p/32. Bits above pin 94 and any other address read as 0.
- R6: A write to a status word clears each bit written as 1 and leaves bits written as 0 untouched; writing 0xFFFFFFFF clears the whole word.
- R7: When an event and a write-one-to-clear reach the same status bit on the same clock edge, the bit ends up set.
- R8: Status bits are recorded whether or not the pin's enable bit is set.
- R9: The interrupt output is 1 exactly one clock after some pin has both its status and enable bit set, and 0 one clock after no such pin remains.
- R10: A pin whose usage qualifier is not set to GPIO, or whose input sensing is off, never sets its status bit.
- R11: After reset all status and enable bits and the interrupt output are 0.
- R12: A write to an enable word replaces the whole word with the written data; enable bits change only on such writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pinLevel | input | 95 | Synchronized pin levels |
| trigSel | input | 95 | Per-pin trigger type: 0 edge, 1 level |
| trigInv | input | 95 | Per-pin polarity: 0 rising/low, 1 falling/high |
| gpioMode | input | 95 | Per-pin qualifier: pin is used as GPIO |
| senseEn | input | 95 | Per-pin qualifier: input sensing enabled |
| busWrEn | input | 1 | Register write strobe |
| busAddr | input | 8 | Register byte address |
| busWrData | input | 32 | Register write data |
| busRdData | output | 32 | Register read data for busAddr, combinational |
| irqOut | output | 1 | Registered summary interrupt to the parent |

## Verification
The two functions that collide are event capture and software clear: a write-one-to-clear to a status word and a new event on the same bit can land on one clock edge. The bench provokes this twice, once by raising an edge-triggered pin in the very cycle its clear is written, and once by clearing a level-triggered pin whose level is still asserted. In both cases the bit must read back as set after the write, and it must read 0 only after the cause has gone away and a second clear is written.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  // Width of one register word on the bus.
  localparam int WORD_W    = 32;
  // Upper bound on register words per kind carried by the strobe struct.
  localparam int MAX_WORDS = 8;

  // Strobes from the bus decoder to the detection datapath.
  typedef struct packed {
    logic [MAX_WORDS-1:0] stsClr;  // write-one-to-clear to status word k
    logic [MAX_WORDS-1:0] enWr;    // full write to enable word k
    logic [MAX_WORDS-1:0] stsRd;   // read selects status word k
    logic [MAX_WORDS-1:0] enRd;    // read selects enable word k
    logic [WORD_W-1:0]    wrData;  // write data
  } irq_strobe_t;

endpackage

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int NUM_WORDS = 3,
  parameter int ADDR_W    = 8,
  parameter int STS_BASE  = 'h80,
  parameter int EN_BASE   = 'h90
) (
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [WORD_W-1:0] busWrData,
  output irq_strobe_t       strb
);

  localparam int WORD_BYTES = WORD_W / 8;

  logic [NUM_WORDS-1:0] hitSts;
  logic [NUM_WORDS-1:0] hitEn;

  // One address comparator per register word.
  for (genvar k = 0; k < NUM_WORDS; k++) begin : gDec
    assign hitSts[k] = (busAddr == ADDR_W'(STS_BASE + WORD_BYTES * k));
    assign hitEn[k]  = (busAddr == ADDR_W'(EN_BASE + WORD_BYTES * k));
  end

  always_comb begin
    strb        = '0;
    strb.wrData = busWrData;
    for (int k = 0; k < NUM_WORDS; k++) begin
      strb.stsRd[k]  = hitSts[k];
      strb.enRd[k]   = hitEn[k];
      strb.stsClr[k] = hitSts[k] & busWrEn;
      strb.enWr[k]   = hitEn[k] & busWrEn;
    end
  end

endmodule

// File: rtl/gpio_irq_datapath.sv
module gpio_irq_datapath
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS  = 95,
  parameter int NUM_WORDS = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pinLevel,
  input  logic [NUM_PINS-1:0] trigSel,
  input  logic [NUM_PINS-1:0] trigInv,
  input  logic [NUM_PINS-1:0] gpioMode,
  input  logic [NUM_PINS-1:0] senseEn,
  input  irq_strobe_t         strb,
  output logic [NUM_PINS-1:0] stsVec,
  output logic [NUM_PINS-1:0] enVec,
  output logic [WORD_W-1:0]   rdData,
  output logic                irqOut
);

  localparam int PAD_W = NUM_WORDS * WORD_W;

  logic [NUM_PINS-1:0] prevLevel;
  logic                primed;
  logic [NUM_PINS-1:0] hitVec;
  logic [NUM_PINS-1:0] stsNext;
  logic [NUM_PINS-1:0] enNext;
  logic [PAD_W-1:0]    clrPad;
  logic [PAD_W-1:0]    enMaskPad;
  logic [PAD_W-1:0]    enDataPad;
  logic [PAD_W-1:0]    stsPad;
  logic [PAD_W-1:0]    enPad;

  // Per-pin event detection. Edges need one earlier sample, hence primed.
  for (genvar p = 0; p < NUM_PINS; p++) begin : gPin
    logic riseEv;
    logic fallEv;
    logic edgeEv;
    logic levelEv;
    assign riseEv    = primed & pinLevel[p] & ~prevLevel[p];
    assign fallEv    = primed & ~pinLevel[p] & prevLevel[p];
    assign edgeEv    = trigInv[p] ? fallEv : riseEv;
    assign levelEv   = ~(pinLevel[p] ^ trigInv[p]);
    assign hitVec[p] = gpioMode[p] & senseEn[p] & (trigSel[p] ? levelEv : edgeEv);
  end

  // Expand word strobes into bank-wide masks.
  always_comb begin
    clrPad    = '0;
    enMaskPad = '0;
    enDataPad = '0;
    for (int k = 0; k < NUM_WORDS; k++) begin
      if (strb.stsClr[k]) begin
        clrPad[k*WORD_W +: WORD_W] = strb.wrData;
      end
      if (strb.enWr[k]) begin
        enMaskPad[k*WORD_W +: WORD_W] = '1;
        enDataPad[k*WORD_W +: WORD_W] = strb.wrData;
      end
    end
  end

  // A fresh event overrides a clear of the same bit.
  assign stsNext = (stsVec & ~clrPad[NUM_PINS-1:0]) | hitVec;
  assign enNext  = (enVec & ~enMaskPad[NUM_PINS-1:0])
                 | (enDataPad[NUM_PINS-1:0] & enMaskPad[NUM_PINS-1:0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prevLevel <= '0;
      primed    <= 1'b0;
      stsVec    <= '0;
      enVec     <= '0;
      irqOut    <= 1'b0;
    end else begin
      prevLevel <= pinLevel;
      primed    <= 1'b1;
      stsVec    <= stsNext;
      enVec     <= enNext;
      irqOut    <= |(stsVec & enVec);
    end
  end

  // Readback: padded words, unused top bits read 0.
  assign stsPad = PAD_W'(stsVec);
  assign enPad  = PAD_W'(enVec);

  always_comb begin
    rdData = '0;
    for (int k = 0; k < NUM_WORDS; k++) begin
      if (strb.stsRd[k]) rdData = rdData | stsPad[k*WORD_W +: WORD_W];
      if (strb.enRd[k])  rdData = rdData | enPad[k*WORD_W +: WORD_W];
    end
  end

  logic unusedBits;
  assign unusedBits = ^{strb, clrPad, enMaskPad, enDataPad};

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 95,
  parameter int ADDR_W   = 8,
  parameter int STS_BASE = 'h80,
  parameter int EN_BASE  = 'h90
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pinLevel,
  input  logic [NUM_PINS-1:0] trigSel,
  input  logic [NUM_PINS-1:0] trigInv,
  input  logic [NUM_PINS-1:0] gpioMode,
  input  logic [NUM_PINS-1:0] senseEn,
  input  logic                busWrEn,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [WORD_W-1:0]   busWrData,
  output logic [WORD_W-1:0]   busRdData,
  output logic                irqOut
);

  localparam int NUM_WORDS = (NUM_PINS + WORD_W - 1) / WORD_W;

  irq_strobe_t         strb;
  logic [NUM_PINS-1:0] stsVec;
  logic [NUM_PINS-1:0] enVec;

  gpio_irq_ctrl #(
    .NUM_WORDS(NUM_WORDS),
    .ADDR_W   (ADDR_W),
    .STS_BASE (STS_BASE),
    .EN_BASE  (EN_BASE)
  ) uCtrl (
    .busWrEn  (busWrEn),
    .busAddr  (busAddr),
    .busWrData(busWrData),
    .strb     (strb)
  );

  gpio_irq_datapath #(
    .NUM_PINS (NUM_PINS),
    .NUM_WORDS(NUM_WORDS)
  ) uDp (
    .clk     (clk),
    .rst_n   (rst_n),
    .pinLevel(pinLevel),
    .trigSel (trigSel),
    .trigInv (trigInv),
    .gpioMode(gpioMode),
    .senseEn (senseEn),
    .strb    (strb),
    .stsVec  (stsVec),
    .enVec   (enVec),
    .rdData  (busRdData),
    .irqOut  (irqOut)
  );

endmodule

// File: rtl/gpio_irq_detect_chk.sv
module gpio_irq_detect_chk #(
  parameter int NUM_PINS = 95
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NUM_PINS-1:0] pinLevel,
  input logic [NUM_PINS-1:0] trigSel,
  input logic [NUM_PINS-1:0] trigInv,
  input logic [NUM_PINS-1:0] gpioMode,
  input logic [NUM_PINS-1:0] senseEn,
  input logic                busWrEn,
  input logic [NUM_PINS-1:0] stsVec,
  input logic [NUM_PINS-1:0] enVec,
  input logic                irqOut
);

  logic [NUM_PINS-1:0] qualified;
  logic [NUM_PINS-1:0] levelActive;
  logic                anyPending;

  assign qualified   = gpioMode & senseEn;
  assign levelActive = qualified & trigSel & ~(pinLevel ^ trigInv);
  assign anyPending  = |(stsVec & enVec);

  AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    anyPending |=> irqOut);  // R9

  AST_IRQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !anyPending |=> !irqOut);  // R9

  AST_NO_STRAY_SET: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stsVec & ~$past(stsVec) & ~$past(qualified)) == '0));  // R10

  AST_LEVEL_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(levelActive) & ~stsVec) == '0));  // R3

  AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !busWrEn |=> $stable(enVec));  // R12

endmodule

bind gpio_irq_detect gpio_irq_detect_chk #(.NUM_PINS(NUM_PINS)) uChk (
  .clk     (clk),
  .rst_n   (rst_n),
  .pinLevel(pinLevel),
  .trigSel (trigSel),
  .trigInv (trigInv),
  .gpioMode(gpioMode),
  .senseEn (senseEn),
  .busWrEn (busWrEn),
  .stsVec  (stsVec),
  .enVec   (enVec),
  .irqOut  (irqOut)
);

// File: tb/sim_gpio_irq_detect.sv
`timescale 1ns/100ps
module sim_gpio_irq_detect;

  localparam int NP = 95;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] pinLevel = '0;
  logic [NP-1:0] trigSel = '0;
  logic [NP-1:0] trigInv = '0;
  logic [NP-1:0] gpioMode = '1;
  logic [NP-1:0] senseEn = '1;
  logic          busWrEn = 1'b0;
  logic [7:0]    busAddr = '0;
  logic [31:0]   busWrData = '0;
  logic [31:0]   busRdData;
  logic          irqOut;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gpio_irq_detect u0 (
    .clk(clk), .rst_n(rst_n), .pinLevel(pinLevel), .trigSel(trigSel),
    .trigInv(trigInv), .gpioMode(gpioMode), .senseEn(senseEn),
    .busWrEn(busWrEn), .busAddr(busAddr), .busWrData(busWrData),
    .busRdData(busRdData), .irqOut(irqOut)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] addr, input logic [31:0] data);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = addr; busWrData = data;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic readExpect(input logic [7:0] addr, input logic [31:0] exp,
                            input string req);
    @(negedge clk);
    busAddr = addr;
    #0.5;
    check(busRdData === exp, req, busRdData, exp);
  endtask

  task automatic setPin(input int p, input logic v);
    @(negedge clk);
    pinLevel[p] = v;
  endtask

  task automatic t_reset();
    for (int k = 0; k < 3; k++) begin
      readExpect(8'h80 + 8'(4 * k), 32'h0, "R11 status");
      readExpect(8'h90 + 8'(4 * k), 32'h0, "R11 enable");
    end
    check(irqOut === 1'b0, "R11 irq", 32'(irqOut), 32'h0);
  endtask

  task automatic t_rise();
    setPin(5, 1'b1);
    readExpect(8'h80, 32'h20, "R1 rise sets");
    busWrite(8'h80, 32'h20);
    readExpect(8'h80, 32'h0, "R1 no re-set while high");
    setPin(5, 1'b0);
    readExpect(8'h80, 32'h0, "R1 fall ignored");
  endtask

  task automatic t_fall();
    @(negedge clk); trigInv[40] = 1'b1;
    setPin(40, 1'b1);
    readExpect(8'h84, 32'h0, "R2 rise ignored");
    setPin(40, 1'b0);
    readExpect(8'h84, 32'h100, "R2 fall sets");
    busWrite(8'h84, 32'hFFFF_FFFF);
    readExpect(8'h84, 32'h0, "R2 cleared");
  endtask

  task automatic t_levelLow();
    @(negedge clk); pinLevel[70] = 1'b1; trigSel[70] = 1'b1;
    readExpect(8'h88, 32'h0, "R3 high ignored");
    setPin(70, 1'b0);
    readExpect(8'h88, 32'h40, "R3 low sets");
    busWrite(8'h88, 32'h40);
    readExpect(8'h88, 32'h40, "R3 R7 re-set while low");
    setPin(70, 1'b1);
    busWrite(8'h88, 32'h40);
    readExpect(8'h88, 32'h0, "R3 clear after release");
    @(negedge clk); trigSel[70] = 1'b0;
    setPin(70, 1'b0);
    readExpect(8'h88, 32'h0, "R3 restore quiet");
  endtask

  task automatic t_levelHigh();
    @(negedge clk); trigSel[94] = 1'b1; trigInv[94] = 1'b1;
    readExpect(8'h88, 32'h0, "R4 low ignored");
    setPin(94, 1'b1);
    readExpect(8'h88, 32'h4000_0000, "R4 high sets");
    setPin(94, 1'b0);
    busWrite(8'h88, 32'h4000_0000);
    readExpect(8'h88, 32'h0, "R4 cleared");
    @(negedge clk); trigSel[94] = 1'b0; trigInv[94] = 1'b0;
  endtask

  task automatic t_qualify();
    @(negedge clk); gpioMode[3] = 1'b0; senseEn[4] = 1'b0;
    @(negedge clk); pinLevel[3] = 1'b1; pinLevel[4] = 1'b1;
    readExpect(8'h80, 32'h0, "R10 unqualified pins silent");
    @(negedge clk); pinLevel[3] = 1'b0; pinLevel[4] = 1'b0;
    @(negedge clk); gpioMode[3] = 1'b1; senseEn[4] = 1'b1;
    readExpect(8'h80, 32'h0, "R10 restore silent");
  endtask

  task automatic t_w1c();
    @(negedge clk); pinLevel[2:0] = 3'b111;
    readExpect(8'h80, 32'h7, "R6 three set");
    busWrite(8'h80, 32'h2);
    readExpect(8'h80, 32'h5, "R6 single bit cleared");
    busWrite(8'h80, 32'h0);
    readExpect(8'h80, 32'h5, "R6 zero write no effect");
    busWrite(8'h80, 32'hFFFF_FFFF);
    readExpect(8'h80, 32'h0, "R6 full clear");
    @(negedge clk); pinLevel[2:0] = 3'b000;
    readExpect(8'h80, 32'h0, "R6 falls ignored");
  endtask

  task automatic t_enable();
    busWrite(8'h94, 32'h0000_F00F);
    readExpect(8'h94, 32'h0000_F00F, "R12 enable word1");
    busWrite(8'h98, 32'hFFFF_FFFF);
    readExpect(8'h98, 32'h7FFF_FFFF, "R5 top bits read 0");
    busWrite(8'h94, 32'h0000_0001);
    readExpect(8'h94, 32'h1, "R12 word replaced");
    readExpect(8'h8C, 32'h0, "R5 unmapped reads 0");
    busWrite(8'h80, 32'hFFFF_FFFF);
    readExpect(8'h90, 32'h0, "R12 status write leaves enable");
    busWrite(8'h94, 32'h0);
    busWrite(8'h98, 32'h0);
    readExpect(8'h98, 32'h0, "R12 disabled");
  endtask

  task automatic t_irq();
    setPin(33, 1'b1);
    readExpect(8'h84, 32'h2, "R8 recorded while disabled");
    check(irqOut === 1'b0, "R8 no irq while disabled", 32'(irqOut), 32'h0);
    busWrite(8'h94, 32'h2);
    check(irqOut === 1'b0, "R9 irq not before register", 32'(irqOut), 32'h0);
    @(negedge clk);
    check(irqOut === 1'b1, "R9 irq rises", 32'(irqOut), 32'h1);
    busWrite(8'h84, 32'h2);
    check(irqOut === 1'b1, "R9 irq held one cycle", 32'(irqOut), 32'h1);
    @(negedge clk);
    check(irqOut === 1'b0, "R9 irq falls", 32'(irqOut), 32'h0);
    setPin(33, 1'b0);
    busWrite(8'h94, 32'h0);
  endtask

  task automatic t_sameCycle();
    setPin(10, 1'b1);
    readExpect(8'h80, 32'h400, "R7 initial set");
    setPin(10, 1'b0);
    @(negedge clk);
    pinLevel[10] = 1'b1;
    busWrEn = 1'b1; busAddr = 8'h80; busWrData = 32'h400;
    @(negedge clk);
    busWrEn = 1'b0;
    readExpect(8'h80, 32'h400, "R7 set wins over clear");
    busWrite(8'h80, 32'h400);
    readExpect(8'h80, 32'h0, "R7 later clear");
    setPin(10, 1'b0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_rise();
    t_fall();
    t_levelLow();
    t_levelHigh();
    t_qualify();
    t_w1c();
    t_enable();
    t_irq();
    t_sameCycle();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=0x%08h expected=0x%08h", 32'h0, 32'h1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule